// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is the clocked control path of a pipelined burst SRAM, built around a small internal memory array. On every rising clock edge it takes one of four actions. It can start a burst from the external address, on either of two start strobes, or end the burst by deselecting. Otherwise it continues the current burst: it advances through a four-beat sequence or holds the address for a wait state. Each access is a read or a byte-lane write. Read data passes through two registers before it reaches the output. Writes can cover every lane at once or only a chosen set of lanes.

A host drives the start strobe for new bursts. A second controller can use the control-side strobe instead, and that strobe also carries the write request on its start edge. Two inputs act without a clock: the output-enable input and the burst-order select. A sleep input stops all activity at once and keeps every stored word and every register. After the sleep input falls, the block ignores a fixed number of clock edges before it accepts accesses again.

Top module: `bsram_burst_ctrl`

## Requirements
- R1: A host start edge (`host_start_n` low, `sel` high) loads `addr` and issues a read of it. The data does not drive the outputs after that edge. It appears on `rdata` with `rdata_oe` all ones after the next rising edge.
- R2: A control start edge (`ctl_start_n` low, `host_start_n` high, `sel` high) loads `addr`. On that same edge it samples the write strobes. If any lane is selected, `wdata` is written to `addr`. Otherwise the edge is a read of `addr`.
- R3: When `host_start_n` and `ctl_start_n` are both low with `sel` high, the host start wins. The write strobes are ignored and the edge is a read.
- R4: A low `host_start_n` while `sel` is low starts nothing. If no burst is active, no read follows and `rdata_oe` stays zero.
- R5: `ctl_start_n` low with `host_start_n` high and `sel` low ends the burst. Later continuation edges perform no access.
- R6: On a continuation edge with `burst_adv_n` low, the beat counter steps by one. Address bits [1:0] become (start + beat) mod 4 when `order_ilv` is 0, and start XOR beat when it is 1. The upper address bits stay fixed and the sequence wraps after four beats.
- R7: On a continuation edge with `burst_adv_n` high, the address is kept and the same word is read again (a wait state).
- R8: Lane i is `wdata`/`rdata` bits [i*9+8:i*9]. With `all_wr_n` low, every lane is written whatever the byte strobes are. With `all_wr_n` high, lane i is written only when `byte_wr_n` and `lane_wr_n[i]` are both low. With no lane selected, the edge is a read.
- R9: An edge that performs a write captures `wdata` on that edge and turns `rdata_oe` off after it, whatever `out_en_n` is.
- R10: `rdata_oe` is driven only while `out_en_n` is low. A high `out_en_n` turns every lane off without a clock edge.
- R11: While `sleep_req` is high, `rdata_oe` is zero at once and no edge writes or changes state. Stored words, the burst position and the read pipeline are kept.
- R12: After `sleep_req` falls, the first two rising edges are ignored and outputs stay off. After the second of them, the held read data is driven again and accesses resume.
- R13: After reset, no burst is active and `rdata_oe` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| sel | input | 1 | Chip select, active high |
| host_start_n | input | 1 | Host-side burst start, active low, highest priority |
| ctl_start_n | input | 1 | Control-side burst start, active low, write-sampling |
| burst_adv_n | input | 1 | Low advances the burst, high inserts a wait state |
| all_wr_n | input | 1 | Low writes all lanes |
| byte_wr_n | input | 1 | Low enables per-lane write strobes |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| sleep_req | input | 1 | High enters power-down |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | External word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data from the output stage |
| rdata_oe | output | LANES | Per-lane output drive enable |

## Verification
A beat counter with the wrong value, or the wrong order mode, reads the wrong word. The bench detects this one edge after the faulty access, because every read burst is compared word by word against an array model in which each address holds a distinct value. A stale pipeline valid bit shows up as `rdata_oe` either one edge early or missing right after a write edge. A wrong wake-up count shows up after the first or the second edge following sleep. At that point either the outputs reappear too early, or a write held on the strobes reaches memory, and a later read of the burst addresses exposes it.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;
endpackage

// File: rtl/bsram_burst_seq.sv
`timescale 1ns/1ps
module bsram_burst_seq #(
   parameter int BURST_BITS = 2
) (
   input  logic [BURST_BITS-1:0] start_lo,
   input  logic [BURST_BITS-1:0] beat,
   input  logic                  order_ilv,
   output logic [BURST_BITS-1:0] seq_lo
);
   if (BURST_BITS < 1) begin : g_bad_bits
      $error("bsram_burst_seq: BURST_BITS must be at least 1");
   end

   logic [BURST_BITS-1:0] lin_lo;
   logic [BURST_BITS-1:0] ilv_lo;

   // linear order wraps by modular addition, interleaved order by XOR
   assign lin_lo = start_lo + beat;
   assign ilv_lo = start_lo ^ beat;
   assign seq_lo = order_ilv ? ilv_lo : lin_lo;
endmodule

// File: rtl/bsram_lane_dec.sv
`timescale 1ns/1ps
module bsram_lane_dec #(
   parameter int LANES = 4
) (
   input  logic             all_wr_n,
   input  logic             byte_wr_n,
   input  logic [LANES-1:0] lane_wr_n,
   output logic [LANES-1:0] lane_sel,
   output logic             any_sel
);
   if (LANES < 1) begin : g_bad_lanes
      $error("bsram_lane_dec: LANES must be at least 1");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_sel[i] = !all_wr_n || (!byte_wr_n && !lane_wr_n[i]);
   end

   assign any_sel = |lane_sel;
endmodule

// File: rtl/bsram_wake.sv
`timescale 1ns/1ps
module bsram_wake #(
   parameter int WAKE_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   output logic awake
);
   if (WAKE_CYCLES < 1) begin : g_bad_wake
      $error("bsram_wake: WAKE_CYCLES must be at least 1");
   end

   localparam int CW = $clog2(WAKE_CYCLES + 1);

   logic [CW-1:0] wait_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_cnt <= '0;
      end else if (sleep_req) begin
         wait_cnt <= CW'(WAKE_CYCLES);
      end else if (wait_cnt != '0) begin
         wait_cnt <= wait_cnt - CW'(1);
      end
   end

   assign awake = !sleep_req && (wait_cnt == '0);
endmodule

// File: rtl/bsram_lane_mem.sv
`timescale 1ns/1ps
module bsram_lane_mem #(
   parameter int ADDR_W = 6,
   parameter int WIDTH  = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] adr,
   input  logic [WIDTH-1:0]  din,
   output logic [WIDTH-1:0]  dout
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WIDTH-1:0] cells [DEPTH];

   // first pipeline stage: the data-out register is loaded on the access edge
   always_ff @(posedge clk) begin
      if (we) begin
         cells[adr] <= din;
      end
      if (re) begin
         dout <= cells[adr];
      end
   end
endmodule

// File: rtl/bsram_burst_ctrl.sv
`timescale 1ns/1ps
module bsram_burst_ctrl
   import bsram_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int LANES       = 4,
   parameter int LANE_W      = 9,
   parameter int BURST_BITS  = 2,
   parameter int WAKE_CYCLES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel,
   input  logic                    host_start_n,
   input  logic                    ctl_start_n,
   input  logic                    burst_adv_n,
   input  logic                    all_wr_n,
   input  logic                    byte_wr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    out_en_n,
   input  logic                    sleep_req,
   input  logic                    order_ilv,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic [LANES-1:0]        rdata_oe
);
   localparam int DW   = LANES * LANE_W;
   localparam int HI_W = ADDR_W - BURST_BITS;

   if (ADDR_W <= BURST_BITS) begin : g_bad_addr
      $error("bsram_burst_ctrl: ADDR_W must exceed BURST_BITS");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("bsram_burst_ctrl: LANE_W must be at least 1");
   end

   logic                  awake;
   logic                  burst_act;
   logic [ADDR_W-1:0]     base_q;
   logic [BURST_BITS-1:0] step_q;
   logic [BURST_BITS-1:0] step_nx;
   logic [BURST_BITS-1:0] seq_lo;
   logic                  host_go;
   logic                  ctl_go;
   logic                  desel;
   logic                  cont;
   logic [LANES-1:0]      lane_sel;
   logic                  any_sel;
   logic [LANES-1:0]      lane_we;
   acc_e                  acc;
   logic [ADDR_W-1:0]     acc_addr;
   logic                  s1_vld;
   logic                  s2_vld;
   logic                  drive;

   bsram_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .awake     (awake)
   );

   bsram_lane_dec #(.LANES(LANES)) u_dec (
      .all_wr_n  (all_wr_n),
      .byte_wr_n (byte_wr_n),
      .lane_wr_n (lane_wr_n),
      .lane_sel  (lane_sel),
      .any_sel   (any_sel)
   );

   bsram_burst_seq #(.BURST_BITS(BURST_BITS)) u_seq (
      .start_lo  (base_q[BURST_BITS-1:0]),
      .beat      (step_nx),
      .order_ilv (order_ilv),
      .seq_lo    (seq_lo)
   );

   // edge classification: host start outranks control start; a host start
   // without chip select falls through to a continuation edge
   always_comb begin
      host_go = awake && sel && !host_start_n;
      ctl_go  = awake && sel && host_start_n && !ctl_start_n;
      desel   = awake && !sel && host_start_n && !ctl_start_n;
      cont    = awake && burst_act && !host_go && !ctl_go && !desel;
      step_nx = (cont && !burst_adv_n) ? step_q + BURST_BITS'(1) : step_q;

      acc = ACC_IDLE;
      if (host_go) begin
         acc = ACC_READ;
      end else if (ctl_go || cont) begin
         acc = any_sel ? ACC_WRITE : ACC_READ;
      end

      if (host_go || ctl_go) begin
         acc_addr = addr;
      end else begin
         acc_addr = {base_q[ADDR_W-1 -: HI_W], seq_lo};
      end
   end

   assign lane_we = (acc == ACC_WRITE) ? lane_sel : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_act <= 1'b0;
         base_q    <= '0;
         step_q    <= '0;
         s1_vld    <= 1'b0;
         s2_vld    <= 1'b0;
      end else if (awake) begin
         if (host_go || ctl_go) begin
            burst_act <= 1'b1;
            base_q    <= addr;
            step_q    <= '0;
         end else if (desel) begin
            burst_act <= 1'b0;
         end else if (cont) begin
            step_q <= step_nx;
         end
         s1_vld <= (acc == ACC_READ);
         s2_vld <= s1_vld && (acc != ACC_WRITE);
      end
   end

   assign drive = awake && !out_en_n && s2_vld;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] stage1;
      logic [LANE_W-1:0] stage2;

      bsram_lane_mem #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_mem (
         .clk  (clk),
         .we   (lane_we[i]),
         .re   (acc == ACC_READ),
         .adr  (acc_addr),
         .din  (wdata[i*LANE_W +: LANE_W]),
         .dout (stage1)
      );

      // second pipeline stage: the output register advances on awake edges
      always_ff @(posedge clk) begin
         if (awake) begin
            stage2 <= stage1;
         end
      end

      assign rdata[i*LANE_W +: LANE_W] = stage2;
      assign rdata_oe[i]               = drive;
   end

   logic [DW-1:0] unused_dw;
   assign unused_dw = '0;
endmodule

// File: rtl/bsram_burst_ctrl_chk.sv
`timescale 1ns/1ps
module bsram_burst_ctrl_chk #(
   parameter int LANES      = 4,
   parameter int BURST_BITS = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sel,
   input logic                  host_start_n,
   input logic                  ctl_start_n,
   input logic                  burst_adv_n,
   input logic                  sleep_req,
   input logic [LANES-1:0]      rdata_oe,
   input logic                  awake,
   input logic                  burst_act,
   input logic [BURST_BITS-1:0] step_q,
   input logic [LANES-1:0]      lane_we
);
   a_r3_host_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !host_start_n) |-> (lane_we == '0))
      else $error("R3: write reached a lane on a host start edge");

   a_r11_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |-> (lane_we == '0))
      else $error("R11: write reached a lane during sleep");

   a_r12_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_req) |=> (rdata_oe == '0))
      else $error("R12: outputs driven during wake-up");

   a_r5_desel_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (awake && !sel && host_start_n && !ctl_start_n) |=> !burst_act)
      else $error("R5: burst still active after deselect");

   a_r9_wr_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_we) |=> (rdata_oe == '0))
      else $error("R9: outputs driven after a write edge");

   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (awake && burst_act && host_start_n && ctl_start_n && burst_adv_n)
         |=> $stable(step_q))
      else $error("R7: burst position moved during a wait state");
endmodule

bind bsram_burst_ctrl bsram_burst_ctrl_chk #(
   .LANES      (LANES),
   .BURST_BITS (BURST_BITS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sel          (sel),
   .host_start_n (host_start_n),
   .ctl_start_n  (ctl_start_n),
   .burst_adv_n  (burst_adv_n),
   .sleep_req    (sleep_req),
   .rdata_oe     (rdata_oe),
   .awake        (awake),
   .burst_act    (burst_act),
   .step_q       (step_q),
   .lane_we      (lane_we)
);

// File: tb/bsram_burst_ctrl_test.sv
`timescale 1ns/1ps
module bsram_burst_ctrl_test;
   localparam int AW = 6;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel, host_start_n, ctl_start_n, burst_adv_n;
   logic          all_wr_n, byte_wr_n, out_en_n, sleep_req, order_ilv;
   logic [NL-1:0] lane_wr_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata;
   logic [DW-1:0] rdata;
   logic [NL-1:0] rdata_oe;

   logic [DW-1:0] ref_m [1 << AW];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bsram_burst_ctrl uut (
      .clk (clk), .rst_n (rst_n), .sel (sel),
      .host_start_n (host_start_n), .ctl_start_n (ctl_start_n),
      .burst_adv_n (burst_adv_n), .all_wr_n (all_wr_n), .byte_wr_n (byte_wr_n),
      .lane_wr_n (lane_wr_n), .out_en_n (out_en_n), .sleep_req (sleep_req),
      .order_ilv (order_ilv), .addr (addr), .wdata (wdata),
      .rdata (rdata), .rdata_oe (rdata_oe)
   );

   function automatic logic [DW-1:0] pat(input int a, input int k);
      return DW'(a * 32'h0001_0203 + k * 32'h0765_4321 + 32'h9);
   endfunction

   function automatic logic [AW-1:0] seq(input logic [AW-1:0] b, input int i,
                                         input bit il);
      logic [1:0] beat;
      logic [1:0] lo;
      beat = 2'(i);
      lo = il ? (b[1:0] ^ beat) : (b[1:0] + beat);
      return {b[AW-1:2], lo};
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle_in();
      sel = 1'b1; host_start_n = 1'b1; ctl_start_n = 1'b1; burst_adv_n = 1'b1;
      all_wr_n = 1'b1; byte_wr_n = 1'b1; lane_wr_n = '1; out_en_n = 1'b0;
   endtask

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic desel_edge();
      idle_in(); sel = 1'b0; ctl_start_n = 1'b0;
      tick();
      idle_in();
   endtask

   task automatic drain();
      desel_edge();
      tick();
   endtask

   task automatic wr_single(input logic [AW-1:0] a, input logic [DW-1:0] d);
      idle_in(); ctl_start_n = 1'b0; addr = a; all_wr_n = 1'b0; wdata = d;
      tick();
      ref_m[a] = d;
      idle_in();
   endtask

   task automatic read_single(input logic [AW-1:0] a, input string req);
      drain();
      host_start_n = 1'b0; addr = a;
      tick();
      idle_in();
      tick();
      chk(rdata_oe == '1 && rdata == ref_m[a], req, 64'(rdata), 64'(ref_m[a]));
      desel_edge();
   endtask

   task automatic read_burst(input logic [AW-1:0] b, input bit il, input string req);
      drain();
      order_ilv = il; host_start_n = 1'b0; addr = b;
      tick();
      idle_in();
      chk(rdata_oe == '0, "R1 no drive after first edge", 64'(rdata_oe), 64'h0);
      for (int i = 1; i < 4; i++) begin
         burst_adv_n = 1'b0;
         tick();
         chk(rdata_oe == '1 && rdata == ref_m[seq(b, i - 1, il)], req,
             64'(rdata), 64'(ref_m[seq(b, i - 1, il)]));
      end
      desel_edge();
      chk(rdata_oe == '1 && rdata == ref_m[seq(b, 3, il)], req,
          64'(rdata), 64'(ref_m[seq(b, 3, il)]));
      tick();
      chk(rdata_oe == '0, "R5 no access after deselect", 64'(rdata_oe), 64'h0);
   endtask

   task automatic wr_burst(input logic [AW-1:0] b, input bit il);
      drain();
      order_ilv = il; ctl_start_n = 1'b0; addr = b; all_wr_n = 1'b0;
      wdata = pat(b, 77);
      tick();
      ref_m[b] = pat(b, 77);
      for (int i = 1; i < 4; i++) begin
         idle_in(); all_wr_n = 1'b0; burst_adv_n = 1'b0; wdata = pat(b, 80 + i);
         tick();
         ref_m[seq(b, i, il)] = pat(b, 80 + i);
      end
      desel_edge();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle_in();
      sleep_req = 1'b0; order_ilv = 1'b0; addr = '0; wdata = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk(rdata_oe == '0, "R13 reset outputs off", 64'(rdata_oe), 64'h0);

      // R2: fill the whole array with single control-start writes
      for (int a = 0; a < (1 << AW); a++) wr_single(AW'(a), pat(a, 1));
      read_single(6'd5, "R2 control-start write");
      read_single(6'd62, "R2 control-start write");

      // R6: every start offset in both orders, read order against single writes
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 4; s++) begin
            read_burst(AW'(8 + s), bit'(m), m ? "R6 interleaved order" : "R6 linear order");
         end
      end
      // R6 write bursts through continuation edges
      wr_burst(6'd57, 1'b1);
      read_burst(6'd57, 1'b1, "R6 interleaved write burst");
      wr_burst(6'd34, 1'b0);
      read_burst(6'd34, 1'b0, "R6 linear write burst");
      order_ilv = 1'b0;

      // R8: every lane pattern through byte strobes
      for (int p = 0; p < 16; p++) begin
         logic [DW-1:0] v;
         v = pat(p, 200);
         drain();
         ctl_start_n = 1'b0; addr = 6'd20; byte_wr_n = 1'b0; lane_wr_n = ~4'(p);
         wdata = v;
         tick();
         for (int i = 0; i < NL; i++) if (p[i]) ref_m[20][i*LW +: LW] = v[i*LW +: LW];
         idle_in();
         read_single(6'd20, "R8 byte-lane mask");
      end
      drain();
      ctl_start_n = 1'b0; addr = 6'd21; byte_wr_n = 1'b1; lane_wr_n = '0; wdata = '1;
      tick();
      idle_in();
      read_single(6'd21, "R8 lane strobes without byte enable");
      drain();
      ctl_start_n = 1'b0; addr = 6'd22; all_wr_n = 1'b0; byte_wr_n = 1'b1; wdata = pat(22, 9);
      tick();
      ref_m[22] = pat(22, 9);
      idle_in();
      read_single(6'd22, "R8 global write overrides");

      // R3: both starts low with writes requested -> read, no write
      drain();
      host_start_n = 1'b0; ctl_start_n = 1'b0; all_wr_n = 1'b0; addr = 6'd30; wdata = '0;
      tick();
      idle_in();
      tick();
      chk(rdata_oe == '1 && rdata == ref_m[30], "R3 host start priority",
          64'(rdata), 64'(ref_m[30]));
      read_single(6'd30, "R3 memory unchanged");

      // R4: host start blocked without chip select
      drain();
      sel = 1'b0; host_start_n = 1'b0; addr = 6'd31;
      tick();
      idle_in();
      tick();
      chk(rdata_oe == '0, "R4 blocked start", 64'(rdata_oe), 64'h0);
      tick();
      chk(rdata_oe == '0, "R4 blocked start", 64'(rdata_oe), 64'h0);

      // R5: deselect ends a running burst
      drain();
      host_start_n = 1'b0; addr = 6'd40;
      tick();
      desel_edge();
      chk(rdata_oe == '1 && rdata == ref_m[40], "R5 read before deselect",
          64'(rdata), 64'(ref_m[40]));
      burst_adv_n = 1'b0;
      tick();
      chk(rdata_oe == '0, "R5 continuation after deselect", 64'(rdata_oe), 64'h0);
      tick();
      chk(rdata_oe == '0, "R5 continuation after deselect", 64'(rdata_oe), 64'h0);
      idle_in();

      // R7 wait states and R10 unclocked output enable
      drain();
      host_start_n = 1'b0; addr = 6'd12;
      tick();
      idle_in();
      tick();
      chk(rdata == ref_m[12], "R7 wait state", 64'(rdata), 64'(ref_m[12]));
      out_en_n = 1'b1;
      #1;
      chk(rdata_oe == '0, "R10 output enable off", 64'(rdata_oe), 64'h0);
      out_en_n = 1'b0;
      #1;
      chk(rdata_oe == '1, "R10 output enable on", 64'(rdata_oe), 64'hF);
      tick();
      chk(rdata == ref_m[12], "R7 wait state", 64'(rdata), 64'(ref_m[12]));
      burst_adv_n = 1'b0;
      tick();
      chk(rdata == ref_m[12], "R7 advance latency", 64'(rdata), 64'(ref_m[12]));
      burst_adv_n = 1'b1;
      tick();
      chk(rdata == ref_m[13], "R7 held after advance", 64'(rdata), 64'(ref_m[13]));
      tick();
      chk(rdata == ref_m[13], "R7 held after advance", 64'(rdata), 64'(ref_m[13]));

      // R9: a write edge blanks outputs and captures data
      drain();
      host_start_n = 1'b0; addr = 6'd50;
      tick();
      idle_in();
      tick();
      chk(rdata_oe == '1, "R9 read driven", 64'(rdata_oe), 64'hF);
      all_wr_n = 1'b0; wdata = pat(50, 333);
      tick();
      ref_m[50] = pat(50, 333);
      idle_in();
      chk(rdata_oe == '0, "R9 write blanks output", 64'(rdata_oe), 64'h0);
      tick();
      chk(rdata_oe == '0, "R9 write blanks output", 64'(rdata_oe), 64'h0);
      tick();
      chk(rdata_oe == '1 && rdata == ref_m[50], "R9 data captured",
          64'(rdata), 64'(ref_m[50]));

      // R11/R12: sleep and wake-up
      drain();
      host_start_n = 1'b0; addr = 6'd44;
      tick();
      idle_in();
      tick();
      chk(rdata_oe == '1 && rdata == ref_m[44], "R11 before sleep",
          64'(rdata), 64'(ref_m[44]));
      sleep_req = 1'b1;
      #1;
      chk(rdata_oe == '0, "R11 sleep turns outputs off", 64'(rdata_oe), 64'h0);
      all_wr_n = 1'b0; burst_adv_n = 1'b0; wdata = '0;
      repeat (3) tick();
      sleep_req = 1'b0;
      tick();
      chk(rdata_oe == '0, "R12 first wake edge ignored", 64'(rdata_oe), 64'h0);
      tick();
      chk(rdata_oe == '1 && rdata == ref_m[44], "R12 resume after two edges",
          64'(rdata), 64'(ref_m[44]));
      idle_in();
      tick();
      chk(rdata == ref_m[44], "R11 burst position kept", 64'(rdata), 64'(ref_m[44]));
      read_burst(6'd44, 1'b0, "R11 R12 no write while asleep or waking");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule